// File: doc/BRIEF.md
# Nonvolatile Write Guard Controller

This block sits between a small processor register interface and two on-chip nonvolatile arrays: a byte-wide data store and a 14-bit-wide program store. Software selects an array, loads address and data registers, and then starts a read or a write through a control register. Behavioural arrays with a fixed write latency stand in for the real cells. Their contents survive every reset.

A write only begins after three guards have all cleared. A power-up lockout counter must have expired since the last power-on reset. The write-enable bit must be set. A two-step unlock code must have just been written to a key address. Separately, a 2-bit region field blocks self-writes into the bottom part of program memory. Two code-protect inputs shut out the external programming port from each array, and internal access continues as normal while they are active.

A second, non-power-on reset aborts any write that is in progress and records the abort in an error bit. Completion of a write sets an interrupt flag, and this flag drives the interrupt output when its enable bit is set.

Top module: `nvm_write_guard`

## Requirements
- R1: After a power-on reset (por_n low), the control register (address 4) reads 0x00, the interrupt register (address 6) reads 0x00, the high data register (address 2) reads 0x00 and irq is 0.
- R2: For PWRT_CYCLES clock cycles after por_n rises, an otherwise valid write start is refused and the write-start bit (control bit 1) stays 0.
- R3: A write starts only when all of the following hold. Key address 5 has received 0x55 and then 0xAA as the two most recent register writes. The next register write goes to control and sets bit 1 (start) and bit 2 (enable). The stored enable bit is already 1. Any other register write between these steps cancels the sequence.
- R4: The write-start bit stays 1 for WR_LAT cycles after the start. It then clears, the array holds the new value, and interrupt flag bit 0 of address 6 becomes 1. irq equals flag AND enable, where the enable is bit 1 of address 6.
- R5: A control write with bit 0 set copies the addressed word into the data registers by the next cycle. This word comes from program memory when bit 7 is 1, and from the data store when bit 7 is 0, in which case the high byte is 0. Bit 0 always reads back as 0.
- R6: While cp_data is 1, external reads and writes of the data store are refused: ext_grant is 0, ext_rdata is 0 and the contents do not change. Internal reads and writes of the data store work as normal.
- R7: While cp_prog is 1, external reads and writes of program memory are refused. Internal program memory reads and writes are unaffected. The data-store port is unaffected.
- R8: wrt_cfg selects a write-inhibited program memory region of addresses below B. B is 0 for wrt_cfg 0, and for values 1, 2 and 3 it is depth/8, depth/4 and depth/2. An internal write into this region does not start and leaves memory unchanged.
- R9: A program memory write with control bit 4 set erases the whole row of 2^ROW_AW words that contains the address, setting every word to 0x3FFF. Words outside that row are untouched.
- R10: Unimplemented bits read as 0. These are control bits 6:5, high data bits 7:6, high address bits 7:3, the key address and address 7.
- R11: While rst_n is low and por_n is high, the write-start, enable and read bits clear, and the select and erase bits keep their values. The error bit (control bit 3) is set if a write was in progress. An aborted write leaves memory and the interrupt flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | Other reset, synchronous, active low |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register select: 0 data low, 1 addr low, 2 data high, 3 addr high, 4 control, 5 key, 6 interrupt |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| cp_data | input | 1 | Code protect for the data store |
| cp_prog | input | 1 | Code protect for program memory |
| wrt_cfg | input | 2 | Self-write inhibited region select |
| ext_req | input | 1 | External port access request |
| ext_we | input | 1 | External access is a write |
| ext_pm | input | 1 | External access targets program memory |
| ext_addr | input | 11 | External word address |
| ext_wdata | input | 14 | External write data |
| ext_grant | output | 1 | External access allowed |
| ext_rdata | output | 14 | External read data, 0 when refused |
| irq | output | 1 | Write-complete interrupt |

## Verification
The assertions assume the following about the inputs. reg_wr is a one-cycle strobe. rst_n only falls while por_n is high. wrt_cfg and the code-protect inputs do not change during a write. No external write hits the word that an internal write commits in the same cycle. The stimulus respects all of these. It drives every register write as an isolated single-cycle pulse and changes configuration only while the controller is idle. It also keeps external pre-loads of memory apart from internal write windows.

// File: rtl/nvm_write_guard.sv
`timescale 1ns/1ps
module nvm_write_guard #(
  parameter int PWRT_CYCLES = 3600000,
  parameter int WR_LAT      = 4,
  parameter int PM_AW       = 6,
  parameter int EE_AW       = 4,
  parameter int ROW_AW      = 2
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        cp_data,
  input  logic        cp_prog,
  input  logic [1:0]  wrt_cfg,
  input  logic        ext_req,
  input  logic        ext_we,
  input  logic        ext_pm,
  input  logic [10:0] ext_addr,
  input  logic [13:0] ext_wdata,
  output logic        ext_grant,
  output logic [13:0] ext_rdata,
  output logic        irq
);
  localparam int PM_DEPTH  = 1 << PM_AW;
  localparam int EE_DEPTH  = 1 << EE_AW;
  localparam int ROW_WORDS = 1 << ROW_AW;
  localparam int TW = $clog2(PWRT_CYCLES + 2);
  localparam int LW = $clog2(WR_LAT + 2);
  localparam logic [TW-1:0] PWRT_LIM = TW'(PWRT_CYCLES);
  localparam logic [LW-1:0] LAT      = LW'(WR_LAT);
  localparam logic [2:0] A_DLO = 3'd0, A_ALO = 3'd1, A_DHI = 3'd2, A_AHI = 3'd3,
                         A_CTRL = 3'd4, A_KEY = 3'd5, A_IRQ = 3'd6;

  logic [7:0] dlo, alo;
  logic [5:0] dhi;
  logic [2:0] ahi;
  logic memsel, erase_en, wrerr, wren, wr, ien, iflag;
  logic [1:0] seq;
  logic [TW-1:0] pcnt;
  logic [LW-1:0] lcnt;
  logic t_pm, t_erase;
  logic [10:0] t_addr;
  logic [13:0] t_data;
  logic [13:0] pm_mem [PM_DEPTH];
  logic [7:0]  ee_mem [EE_DEPTH];

  function automatic logic [PM_AW:0] bound_of(input logic [1:0] c);
    if (c == 2'd0) return '0;
    return (PM_AW+1)'(PM_DEPTH >> (4 - int'(c)));
  endfunction

  wire [10:0] full_addr = {ahi, alo};
  wire [PM_AW-1:0] pm_idx = full_addr[PM_AW-1:0];
  wire [EE_AW-1:0] ee_idx = alo[EE_AW-1:0];
  wire pwrt_done = (pcnt == PWRT_LIM);
  wire ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
  wire key_wr    = reg_wr && (reg_addr == A_KEY);
  wire new_erase = reg_wdata[4] & reg_wdata[7];
  wire [PM_AW-1:0] base_idx = new_erase ? {pm_idx[PM_AW-1:ROW_AW], {ROW_AW{1'b0}}} : pm_idx;
  wire inhibit   = reg_wdata[7] && ({1'b0, base_idx} < bound_of(wrt_cfg));
  wire start     = ctrl_wr && reg_wdata[1] && reg_wdata[2] && wren && (seq == 2'd2)
                   && pwrt_done && !wr && !inhibit;
  wire commit    = wr && (lcnt == LW'(1));
  wire ext_ok    = ext_pm ? !cp_prog : !cp_data;
  wire unused_ok = ^{ext_addr, full_addr, t_addr, t_data, ext_wdata, reg_wdata};

  assign ext_grant = ext_req & ext_ok;
  assign ext_rdata = !ext_grant ? 14'd0 :
                     ext_pm ? pm_mem[ext_addr[PM_AW-1:0]] : {6'd0, ee_mem[ext_addr[EE_AW-1:0]]};
  assign irq = iflag & ien;

  always_comb begin
    case (reg_addr)
      A_DLO:  reg_rdata = dlo;
      A_ALO:  reg_rdata = alo;
      A_DHI:  reg_rdata = {2'b00, dhi};
      A_AHI:  reg_rdata = {5'd0, ahi};
      A_CTRL: reg_rdata = {memsel, 2'b00, erase_en, wrerr, wren, wr, 1'b0};
      A_IRQ:  reg_rdata = {6'd0, ien, iflag};
      default: reg_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) pcnt <= '0;
    else if (!pwrt_done) pcnt <= pcnt + 1'b1;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      dlo <= '0; alo <= '0; dhi <= '0; ahi <= '0;
      memsel <= 1'b0; erase_en <= 1'b0; wrerr <= 1'b0; wren <= 1'b0; wr <= 1'b0;
      ien <= 1'b0; iflag <= 1'b0; seq <= '0; lcnt <= '0;
      t_pm <= 1'b0; t_erase <= 1'b0; t_addr <= '0; t_data <= '0;
    end else if (!rst_n) begin
      wrerr <= wrerr | wr;
      wren  <= 1'b0;
      wr    <= 1'b0;
      seq   <= '0;
      lcnt  <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_DLO:  dlo <= reg_wdata;
          A_ALO:  alo <= reg_wdata;
          A_DHI:  dhi <= reg_wdata[5:0];
          A_AHI:  ahi <= reg_wdata[2:0];
          A_CTRL: begin
            memsel <= reg_wdata[7]; erase_en <= reg_wdata[4];
            wrerr  <= reg_wdata[3]; wren     <= reg_wdata[2];
          end
          A_IRQ:  begin ien <= reg_wdata[1]; iflag <= reg_wdata[0]; end
          default: ;
        endcase
        if (key_wr && reg_wdata == 8'h55)                     seq <= 2'd1;
        else if (key_wr && reg_wdata == 8'hAA && seq == 2'd1) seq <= 2'd2;
        else                                                  seq <= 2'd0;
      end
      if (ctrl_wr && reg_wdata[0]) begin
        if (reg_wdata[7]) {dhi, dlo} <= pm_mem[pm_idx];
        else begin dhi <= '0; dlo <= ee_mem[ee_idx]; end
      end
      if (start) begin
        wr <= 1'b1; lcnt <= LAT;
        t_pm <= reg_wdata[7]; t_erase <= new_erase;
        t_addr <= full_addr; t_data <= {dhi, dlo};
      end else if (wr) begin
        lcnt <= lcnt - 1'b1;
        if (commit) begin wr <= 1'b0; iflag <= 1'b1; end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ext_grant && ext_we) begin
      if (ext_pm) pm_mem[ext_addr[PM_AW-1:0]] <= ext_wdata;
      else        ee_mem[ext_addr[EE_AW-1:0]] <= ext_wdata[7:0];
    end
    if (commit && rst_n) begin
      if (t_pm && t_erase)
        for (int i = 0; i < ROW_WORDS; i++)
          pm_mem[{t_addr[PM_AW-1:ROW_AW], ROW_AW'(i)}] <= 14'h3FFF;
      else if (t_pm) pm_mem[t_addr[PM_AW-1:0]] <= t_data;
      else           ee_mem[t_addr[EE_AW-1:0]] <= t_data[7:0];
    end
  end

  assert_lockout_R2: assert property (@(posedge clk) disable iff (!por_n)
    !pwrt_done |-> !wr);
  assert_start_key_R3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wr) |-> ($past(seq) == 2'd2) && $past(wren));
  assert_done_flag_R4: assert property (@(posedge clk) disable iff (!por_n)
    $fell(wr) && $past(rst_n) |-> iflag);
  assert_ext_block_R6: assert property (@(posedge clk) disable iff (!por_n)
    ext_req && !ext_pm && cp_data |-> !ext_grant && ext_rdata == 14'd0);
  assert_ext_block_R7: assert property (@(posedge clk) disable iff (!por_n)
    ext_req && ext_pm && cp_prog |-> !ext_grant && ext_rdata == 14'd0);
  assert_rst_clear_R11: assert property (@(posedge clk) disable iff (!por_n)
    !$past(rst_n) |-> !wr && !wren);
  assert_abort_err_R11: assert property (@(posedge clk) disable iff (!por_n)
    !$past(rst_n) && $past(wr) |-> wrerr);
endmodule

// File: tb/nvm_write_guard_bench.sv
`timescale 1ns/1ps
module nvm_write_guard_bench;
  localparam int LAT = 4;
  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b1;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic cp_data = 1'b0, cp_prog = 1'b0;
  logic [1:0] wrt_cfg = '0;
  logic ext_req = 1'b0, ext_we = 1'b0, ext_pm = 1'b0, ext_grant, irq;
  logic [10:0] ext_addr = '0;
  logic [13:0] ext_wdata = '0, ext_rdata;
  int nchk = 0, nerr = 0;
  bit finished = 0;
  int alist[8] = '{0, 7, 8, 15, 16, 31, 32, 63};

  always #10 clk = ~clk;

  nvm_write_guard #(.PWRT_CYCLES(20), .WR_LAT(LAT), .PM_AW(6), .EE_AW(4), .ROW_AW(2))
    u_nvm_write_guard (.clk, .por_n, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
      .cp_data, .cp_prog, .wrt_cfg, .ext_req, .ext_we, .ext_pm, .ext_addr, .ext_wdata,
      .ext_grant, .ext_rdata, .irq);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic ext_wr(input logic pm, input logic [10:0] a, input logic [13:0] d, output logic g);
    @(negedge clk); ext_req = 1'b1; ext_we = 1'b1; ext_pm = pm; ext_addr = a; ext_wdata = d;
    #1; g = ext_grant;
    @(negedge clk); ext_req = 1'b0; ext_we = 1'b0;
  endtask

  task automatic ext_rd(input logic pm, input logic [10:0] a, output logic [13:0] d, output logic g);
    ext_req = 1'b1; ext_we = 1'b0; ext_pm = pm; ext_addr = a;
    #1; d = ext_rdata; g = ext_grant;
    ext_req = 1'b0;
  endtask

  task automatic do_write(input logic pm, input logic er, input logic [10:0] a,
                          input logic [13:0] d, input bit wait_done, output logic started);
    logic [7:0] v;
    wreg(3'd1, a[7:0]); wreg(3'd3, {5'd0, a[10:8]});
    wreg(3'd0, d[7:0]); wreg(3'd2, {2'b00, d[13:8]});
    wreg(3'd4, {pm, 2'b00, er, 1'b0, 1'b1, 2'b00});
    wreg(3'd5, 8'h55); wreg(3'd5, 8'hAA);
    wreg(3'd4, {pm, 2'b00, er, 1'b0, 1'b1, 1'b1, 1'b0});
    rreg(3'd4, v); started = v[1];
    if (wait_done) repeat (LAT + 2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v; logic [13:0] d; logic g, s;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    // R1 reset state
    rreg(3'd4, v); chk("R1 ctrl", v, 8'h00);
    rreg(3'd6, v); chk("R1 irq reg", v, 8'h00);
    rreg(3'd2, v); chk("R1 data high", v, 8'h00);
    chk("R1 irq", irq, 1'b0);
    // R2 lockout
    ext_wr(1'b0, 11'd2, 14'h11, g);
    do_write(1'b0, 1'b0, 11'd2, 14'h5A, 1'b1, s);
    chk("R2 start refused in lockout", s, 1'b0);
    ext_rd(1'b0, 11'd2, d, g); chk("R2 memory untouched", d, 14'h11);
    repeat (25) @(negedge clk);
    do_write(1'b0, 1'b0, 11'd2, 14'h5A, 1'b0, s);
    chk("R2 start after lockout", s, 1'b1);
    repeat (LAT - 2) @(negedge clk);
    rreg(3'd4, v); chk("R4 start bit held", v[1], 1'b1);
    repeat (3) @(negedge clk);
    rreg(3'd4, v); chk("R4 start bit cleared", v[1], 1'b0);
    ext_rd(1'b0, 11'd2, d, g); chk("R4 data written", d, 14'h5A);
    rreg(3'd6, v); chk("R4 flag set", v, 8'h01);
    chk("R4 irq masked", irq, 1'b0);
    wreg(3'd6, 8'h03); chk("R4 irq enabled", irq, 1'b1);
    wreg(3'd6, 8'h02); chk("R4 irq after flag clear", irq, 1'b0);
    wreg(3'd6, 8'h00);
    // R3 unlock sequence negatives
    wreg(3'd0, 8'h77);
    wreg(3'd4, 8'h04); wreg(3'd4, 8'h06);
    rreg(3'd4, v); chk("R3 no key", v[1], 1'b0);
    wreg(3'd4, 8'h00); wreg(3'd5, 8'h55); wreg(3'd5, 8'hAA); wreg(3'd4, 8'h02);
    rreg(3'd4, v); chk("R3 enable clear", v[1], 1'b0);
    wreg(3'd4, 8'h04); wreg(3'd5, 8'h55); wreg(3'd1, 8'h02); wreg(3'd5, 8'hAA); wreg(3'd4, 8'h06);
    rreg(3'd4, v); chk("R3 write between key bytes", v[1], 1'b0);
    wreg(3'd4, 8'h04); wreg(3'd5, 8'h55); wreg(3'd5, 8'hAA); wreg(3'd0, 8'h78); wreg(3'd4, 8'h06);
    rreg(3'd4, v); chk("R3 write before start", v[1], 1'b0);
    wreg(3'd4, 8'h04); wreg(3'd5, 8'hAA); wreg(3'd5, 8'h55); wreg(3'd4, 8'h06);
    rreg(3'd4, v); chk("R3 reversed key", v[1], 1'b0);
    repeat (LAT + 2) @(negedge clk);
    ext_rd(1'b0, 11'd2, d, g); chk("R3 memory unchanged", d, 14'h5A);
    rreg(3'd6, v); chk("R3 no completion flag", v, 8'h00);
    wreg(3'd4, 8'h00);
    // R5 reads
    ext_wr(1'b1, 11'd9, 14'h2A5C, g);
    wreg(3'd1, 8'd9); wreg(3'd3, 8'd0); wreg(3'd4, 8'h81);
    rreg(3'd0, v); chk("R5 pm low", v, 8'h5C);
    rreg(3'd2, v); chk("R5 pm high", v, 8'h2A);
    rreg(3'd4, v); chk("R5 read bit reads 0", v[0], 1'b0);
    ext_wr(1'b0, 11'd3, 14'hC3, g);
    wreg(3'd1, 8'd3); wreg(3'd4, 8'h01);
    rreg(3'd0, v); chk("R5 ee low", v, 8'hC3);
    rreg(3'd2, v); chk("R5 ee high zero", v, 8'h00);
    // R6 data protect
    cp_data = 1'b1;
    ext_wr(1'b0, 11'd3, 14'h00, g); chk("R6 ext write refused", g, 1'b0);
    ext_rd(1'b0, 11'd3, d, g); chk("R6 ext read refused", {g, d}, 15'h0);
    wreg(3'd1, 8'd3); wreg(3'd4, 8'h01);
    rreg(3'd0, v); chk("R6 internal read", v, 8'hC3);
    do_write(1'b0, 1'b0, 11'd4, 14'h99, 1'b1, s); chk("R6 internal write start", s, 1'b1);
    ext_rd(1'b1, 11'd9, d, g); chk("R7 pm port open under data protect", d, 14'h2A5C);
    cp_data = 1'b0;
    ext_rd(1'b0, 11'd4, d, g); chk("R6 internal write landed", d, 14'h99);
    // R7 program protect
    cp_prog = 1'b1;
    ext_rd(1'b1, 11'd9, d, g); chk("R7 ext read refused", {g, d}, 15'h0);
    ext_wr(1'b1, 11'd9, 14'h0001, g); chk("R7 ext write refused", g, 1'b0);
    ext_rd(1'b0, 11'd4, d, g); chk("R7 ee port open", {g, d}, {1'b1, 14'h99});
    wreg(3'd1, 8'd9); wreg(3'd4, 8'h81);
    rreg(3'd0, v); chk("R7 internal read", v, 8'h5C);
    do_write(1'b1, 1'b0, 11'd10, 14'h1234, 1'b1, s);
    cp_prog = 1'b0;
    ext_rd(1'b1, 11'd10, d, g); chk("R7 internal write landed", d, 14'h1234);
    // R8 region sweep
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 8; k++) begin
        int a, b; logic ok; logic [13:0] nv, ov;
        a = alist[k];
        b = (c == 0) ? 0 : (64 >> (4 - c));
        ok = (a >= b);
        ov = 14'h0100 + 14'(a);
        nv = 14'h2000 | (14'(c) << 8) | 14'(a);
        ext_wr(1'b1, 11'(a), ov, g);
        wrt_cfg = 2'(c);
        do_write(1'b1, 1'b0, 11'(a), nv, 1'b1, s);
        chk($sformatf("R8 start cfg%0d addr%0d", c, a), s, ok);
        ext_rd(1'b1, 11'(a), d, g);
        chk($sformatf("R8 content cfg%0d addr%0d", c, a), d, ok ? nv : ov);
      end
    end
    // R9 row erase
    wrt_cfg = 2'd0;
    for (int i = 12; i <= 16; i++) ext_wr(1'b1, 11'(i), 14'(i), g);
    do_write(1'b1, 1'b1, 11'd13, 14'h0, 1'b1, s); chk("R9 erase started", s, 1'b1);
    for (int i = 12; i <= 15; i++) begin
      ext_rd(1'b1, 11'(i), d, g); chk($sformatf("R9 row word %0d", i), d, 14'h3FFF);
    end
    ext_rd(1'b1, 11'd16, d, g); chk("R9 neighbour kept", d, 14'd16);
    // R10 unimplemented bits
    wreg(3'd2, 8'hFF); rreg(3'd2, v); chk("R10 data high", v, 8'h3F);
    wreg(3'd3, 8'hFF); rreg(3'd3, v); chk("R10 addr high", v, 8'h07);
    wreg(3'd4, 8'hFF); rreg(3'd4, v); chk("R10 ctrl", v, 8'h9C);
    wreg(3'd5, 8'h12); rreg(3'd5, v); chk("R10 key reads 0", v, 8'h00);
    rreg(3'd7, v); chk("R10 spare reads 0", v, 8'h00);
    wreg(3'd4, 8'h00); wreg(3'd3, 8'h00);
    // R11 reset during a write
    ext_wr(1'b0, 11'd5, 14'h44, g);
    wreg(3'd6, 8'h00);
    do_write(1'b0, 1'b0, 11'd5, 14'hEE, 1'b0, s); chk("R11 write started", s, 1'b1);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    rreg(3'd4, v); chk("R11 ctrl after abort", v, 8'h08);
    repeat (LAT + 3) @(negedge clk);
    ext_rd(1'b0, 11'd5, d, g); chk("R11 aborted write discarded", d, 14'h44);
    rreg(3'd6, v); chk("R11 no flag on abort", v, 8'h00);
    wreg(3'd4, 8'h94);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    rreg(3'd4, v); chk("R11 idle reset keeps select and erase", v, 8'h90);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule